// File: doc/BRIEF.md
# Supervisor Trap Entry Controller

This block decides, cycle by cycle, whether a small in-order core must leave its current instruction stream for a supervisor handler, and it holds the supervisor control registers that this decision needs. It watches three interrupt request lines, a synchronous exception request, the PC and privilege mode of the instruction now at the commit point, and a return-from-handler strobe. When it decides to redirect, it raises a redirect flag in the same cycle with the target PC and the new privilege mode. At the following clock edge it records the interrupted PC, the cause, the previous mode and the previous global enable, and it clears the global enable.

System calls, faults and device interrupts all use the same entry path. Device interrupts are gated three ways: by their line, by their own enable bit, and by the global enable. Synchronous exceptions ignore the global enable. A return puts the saved enable and mode back and resumes at the saved PC. Software reaches all registers through a small select-addressed read/write port.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, status, enable, epc and cause read 0, the vector register reads RESET_VEC with bits 1:0 cleared, and redirectValid is low.
- R2: A device interrupt causes a trap only when its line is high, its enable bit is set and the global enable (status bit 1) is set. Without an exception or return, no redirect happens and no register changes except through the CSR port.
- R3: A synchronous exception (excReq) causes a trap whatever the enable bits hold, and it wins over any interrupt. The cause then reads MSB 0 with excCode in bits 3:0.
- R4: Among armed interrupts the order is external (line 2), then software (line 0), then timer (line 1). The cause reads MSB 1 with code 9, 1 or 5 respectively.
- R5: In a trap cycle, redirectValid is high, redirectPc equals the vector register and newMode is 1 (supervisor). In a cycle with no redirect, redirectPc is 0 and newMode equals curMode (0 user, 1 supervisor).
- R6: After a trap cycle, epc holds that cycle's curPc, status bit 8 (previous mode) holds that cycle's curMode, status bit 5 (saved enable) holds the old global enable, and status bit 1 reads 0.
- R7: A return strobe without a trap redirects in the same cycle to epc with newMode equal to status bit 8. Afterwards bit 1 takes the old bit 5, bit 5 reads 1 and bit 8 reads 0. A trap in the same cycle overrides the return.
- R8: CSR select values are 0 status, 1 enable, 2 pending, 3 epc, 4 cause, 5 vector, and 6 and 7 read 0. The status register keeps only bits 1, 5 and 8. Enable bits 1, 5 and 9 belong to software, timer and external, and pending shows the live lines at those same bits and ignores writes. The cause register keeps bit 31 and bits 3:0, and the vector register forces bits 1:0 to 0. Reads are combinational. A write in a trap or return cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLines | input | 3 | Request lines: 0 software, 1 timer, 2 external |
| excReq | input | 1 | Synchronous exception or system call at commit |
| excCode | input | 4 | Exception code recorded in cause |
| curPc | input | XLEN | PC of the committing instruction |
| curMode | input | 1 | Current privilege, 0 user, 1 supervisor |
| retStrobe | input | 1 | Return-from-handler request |
| csrWe | input | 1 | CSR write enable |
| csrSel | input | 3 | CSR select |
| csrWdata | input | XLEN | CSR write data |
| csrRdata | output | XLEN | CSR read data |
| redirectValid | output | 1 | Redirect this cycle |
| redirectPc | output | XLEN | Redirect target |
| newMode | output | 1 | Privilege mode after this cycle |

## Verification
A saved enable or previous-mode bit that goes wrong stays invisible until the next return. It then appears as a wrong newMode and as a missing or unexpected interrupt redirect in the cycles that follow. A wrong epc or vector shows as a wrong redirectPc at the very next return or trap. A bad priority or a wrong cause code shows on a cause read one cycle after the trap. The bench reads a random CSR every cycle and checks every redirect, so each of these faults reaches the ports within a few cycles of the event that exposes it.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int CODE_W = 4;

  localparam logic [2:0] SEL_STATUS  = 3'd0;
  localparam logic [2:0] SEL_ENABLE  = 3'd1;
  localparam logic [2:0] SEL_PENDING = 3'd2;
  localparam logic [2:0] SEL_EPC     = 3'd3;
  localparam logic [2:0] SEL_CAUSE   = 3'd4;
  localparam logic [2:0] SEL_VECTOR  = 3'd5;

  localparam logic [CODE_W-1:0] CODE_SOFT = 4'd1;
  localparam logic [CODE_W-1:0] CODE_TIME = 4'd5;
  localparam logic [CODE_W-1:0] CODE_EXT  = 4'd9;

  typedef struct packed {
    logic              takeTrap;
    logic              takeRet;
    logic              isIrq;
    logic [CODE_W-1:0] code;
    logic              csrWrite;
  } strobe_t;
endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        irqLines,
  input  logic              excReq,
  input  logic [CODE_W-1:0] excCode,
  input  logic              retStrobe,
  input  logic              csrWe,
  input  logic              sieBit,
  input  logic [2:0]        ieBits,
  output strobe_t           strb
);
  logic [2:0] armed;
  logic       irqGo;

  assign armed = irqLines & ieBits;
  assign irqGo = sieBit && (armed != 3'b000);

  always_comb begin
    strb = '0;
    if (excReq) begin
      strb.takeTrap = 1'b1;
      strb.code     = excCode;
    end else if (irqGo) begin
      strb.takeTrap = 1'b1;
      strb.isIrq    = 1'b1;
      if (armed[2])      strb.code = CODE_EXT;
      else if (armed[0]) strb.code = CODE_SOFT;
      else               strb.code = CODE_TIME;
    end
    strb.takeRet  = retStrobe && !strb.takeTrap;
    strb.csrWrite = csrWe && !strb.takeTrap && !strb.takeRet;
  end

  // R2: no interrupt trap while the global enable is off
  a_r2_gated_off: assert property (@(posedge clk) disable iff (!rstN)
    (!excReq && !sieBit) |-> !strb.takeTrap);
  // R3: exceptions always enter, as non-interrupt
  a_r3_exc_first: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> (strb.takeTrap && !strb.isIrq));
  // R4: an interrupt trap needs an armed line
  a_r4_armed_only: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeTrap && strb.isIrq) |-> ((irqLines & ieBits) != 3'b000));
endmodule

// File: rtl/strap_dp.sv
module strap_dp
  import strap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] RESET_VEC = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic [2:0]      irqLines,
  input  logic [XLEN-1:0] curPc,
  input  logic            curMode,
  input  logic [2:0]      csrSel,
  input  logic [XLEN-1:0] csrWdata,
  output logic            sieBit,
  output logic [2:0]      ieBits,
  output logic [XLEN-1:0] csrRdata,
  output logic [XLEN-1:0] redirectPc,
  output logic            newMode
);
  localparam int PAD_W = XLEN - 1 - CODE_W;
  localparam int BIT_POS [3] = '{1, 5, 9};

  logic              sieQ, spieQ, sppQ;
  logic [2:0]        ieQ;
  logic [XLEN-1:0]   epcQ;
  logic              causeIrqQ;
  logic [CODE_W-1:0] causeCodeQ;
  logic [XLEN-3:0]   vecQ;
  logic [XLEN-1:0]   ieView, pendView, statusView;

  for (genvar i = 0; i < 3; i++) begin : g_map
    assign ieView[BIT_POS[i]]   = ieQ[i];
    assign pendView[BIT_POS[i]] = irqLines[i];
  end
  for (genvar b = 0; b < XLEN; b++) begin : g_pad
    if (b != 1 && b != 5 && b != 9) begin : g_zero
      assign ieView[b]   = 1'b0;
      assign pendView[b] = 1'b0;
    end
  end

  always_comb begin
    statusView    = '0;
    statusView[1] = sieQ;
    statusView[5] = spieQ;
    statusView[8] = sppQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sieQ <= 1'b0; spieQ <= 1'b0; sppQ <= 1'b0;
      ieQ <= '0; epcQ <= '0;
      causeIrqQ <= 1'b0; causeCodeQ <= '0;
      vecQ <= RESET_VEC[XLEN-1:2];
    end else if (strb.takeTrap) begin
      epcQ       <= curPc;
      causeIrqQ  <= strb.isIrq;
      causeCodeQ <= strb.code;
      sppQ       <= curMode;
      spieQ      <= sieQ;
      sieQ       <= 1'b0;
    end else if (strb.takeRet) begin
      sieQ  <= spieQ;
      spieQ <= 1'b1;
      sppQ  <= 1'b0;
    end else if (strb.csrWrite) begin
      case (csrSel)
        SEL_STATUS: begin
          sieQ <= csrWdata[1]; spieQ <= csrWdata[5]; sppQ <= csrWdata[8];
        end
        SEL_ENABLE: ieQ <= {csrWdata[9], csrWdata[5], csrWdata[1]};
        SEL_EPC:    epcQ <= csrWdata;
        SEL_CAUSE: begin
          causeIrqQ  <= csrWdata[XLEN-1];
          causeCodeQ <= csrWdata[CODE_W-1:0];
        end
        SEL_VECTOR: vecQ <= csrWdata[XLEN-1:2];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (csrSel)
      SEL_STATUS:  csrRdata = statusView;
      SEL_ENABLE:  csrRdata = ieView;
      SEL_PENDING: csrRdata = pendView;
      SEL_EPC:     csrRdata = epcQ;
      SEL_CAUSE:   csrRdata = {causeIrqQ, {PAD_W{1'b0}}, causeCodeQ};
      SEL_VECTOR:  csrRdata = {vecQ, 2'b00};
      default:     csrRdata = '0;
    endcase
  end

  assign redirectPc = strb.takeTrap ? {vecQ, 2'b00} : (strb.takeRet ? epcQ : '0);
  assign newMode    = strb.takeTrap ? 1'b1 : (strb.takeRet ? sppQ : curMode);
  assign sieBit     = sieQ;
  assign ieBits     = ieQ;

  // R6: state captured on entry
  a_r6_capture: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeTrap |=> (epcQ == $past(curPc)) && !sieQ &&
                      (sppQ == $past(curMode)) && (spieQ == $past(sieQ)));
  // R7: status restored on return
  a_r7_restore: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeRet |=> (sieQ == $past(spieQ)) && spieQ && !sppQ);
  // R8: pending view ignores writes and tracks the lines
  a_r8_pending_live: assert property (@(posedge clk) disable iff (!rstN)
    (csrSel == SEL_PENDING) |-> (csrRdata[9] == irqLines[2]));
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import strap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_0400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        irqLines,
  input  logic              excReq,
  input  logic [CODE_W-1:0] excCode,
  input  logic [XLEN-1:0]   curPc,
  input  logic              curMode,
  input  logic              retStrobe,
  input  logic              csrWe,
  input  logic [2:0]        csrSel,
  input  logic [XLEN-1:0]   csrWdata,
  output logic [XLEN-1:0]   csrRdata,
  output logic              redirectValid,
  output logic [XLEN-1:0]   redirectPc,
  output logic              newMode
);
  strobe_t    strb;
  logic       sieBit;
  logic [2:0] ieBits;

  strap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .excReq(excReq),
    .excCode(excCode), .retStrobe(retStrobe), .csrWe(csrWe),
    .sieBit(sieBit), .ieBits(ieBits), .strb(strb)
  );

  strap_dp #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .irqLines(irqLines),
    .curPc(curPc), .curMode(curMode), .csrSel(csrSel), .csrWdata(csrWdata),
    .sieBit(sieBit), .ieBits(ieBits), .csrRdata(csrRdata),
    .redirectPc(redirectPc), .newMode(newMode)
  );

  assign redirectValid = strb.takeTrap | strb.takeRet;

  // R5: a redirect always lands in supervisor mode or a return target
  a_r5_trap_mode: assert property (@(posedge clk) disable iff (!rstN)
    (redirectValid && !retStrobe) |-> newMode);
endmodule

// File: tb/trap_entry_unit_bench.sv
`timescale 1ns/1ps
module trap_entry_unit_bench;
  localparam int XLEN = 32;
  localparam logic [31:0] RVEC = 32'h0000_0400;

  logic clk = 1'b0, rstN = 1'b0;
  logic [2:0] irqLines = '0;
  logic excReq = 1'b0;
  logic [3:0] excCode = '0;
  logic [31:0] curPc = '0;
  logic curMode = 1'b0, retStrobe = 1'b0, csrWe = 1'b0;
  logic [2:0] csrSel = '0;
  logic [31:0] csrWdata = '0;
  logic [31:0] csrRdata, redirectPc;
  logic redirectValid, newMode;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model of the architectural state
  bit mSie, mSpie, mSpp, mCIrq;
  bit [2:0] mIe;
  bit [31:0] mEpc, mVec;
  bit [3:0] mCode;

  always #4 clk = ~clk;

  trap_entry_unit #(.XLEN(XLEN), .RESET_VEC(RVEC)) u_trap_entry_unit (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .excReq(excReq),
    .excCode(excCode), .curPc(curPc), .curMode(curMode),
    .retStrobe(retStrobe), .csrWe(csrWe), .csrSel(csrSel),
    .csrWdata(csrWdata), .csrRdata(csrRdata), .redirectValid(redirectValid),
    .redirectPc(redirectPc), .newMode(newMode)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit [31:0] modelRead(bit [2:0] sel, bit [2:0] lines);
    bit [31:0] v = '0;
    case (sel)
      3'd0: begin v[1] = mSie; v[5] = mSpie; v[8] = mSpp; end
      3'd1: begin v[1] = mIe[0]; v[5] = mIe[1]; v[9] = mIe[2]; end
      3'd2: begin v[1] = lines[0]; v[5] = lines[1]; v[9] = lines[2]; end
      3'd3: v = mEpc;
      3'd4: begin v[31] = mCIrq; v[3:0] = mCode; end
      3'd5: v = mVec;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic step(bit [2:0] irq, bit exc, bit [3:0] code, bit [31:0] pc,
                      bit mode, bit ret, bit we, bit [2:0] sel, bit [31:0] wd);
    bit [2:0] armed;
    bit trap, isIrq, doRet;
    bit [3:0] tcode;
    string tag;
    @(negedge clk);
    irqLines = irq; excReq = exc; excCode = code; curPc = pc; curMode = mode;
    retStrobe = ret; csrWe = we; csrSel = sel; csrWdata = wd;
    armed = irq & mIe;
    isIrq = !exc && mSie && (armed != 0);
    trap = exc || isIrq;
    tcode = exc ? code : (armed[2] ? 4'd9 : (armed[0] ? 4'd1 : 4'd5));
    doRet = ret && !trap;
    #1;
    tag = trap ? (exc ? "R3" : "R4") : (doRet ? "R7" : "R2");
    check(tag, {31'd0, redirectValid}, {31'd0, trap | doRet});
    check(trap ? "R5" : tag, redirectPc, trap ? mVec : (doRet ? mEpc : 32'd0));
    check(trap ? "R5" : tag, {31'd0, newMode},
          {31'd0, trap ? 1'b1 : (doRet ? mSpp : mode)});
    check(sel == 3'd4 ? "R4" : (sel == 3'd0 || sel == 3'd3) ? "R6" : "R8",
          csrRdata, modelRead(sel, irq));
    @(posedge clk);
    if (trap) begin
      mEpc = pc; mCIrq = isIrq; mCode = tcode; mSpp = mode; mSpie = mSie; mSie = 0;
    end else if (doRet) begin
      mSie = mSpie; mSpie = 1; mSpp = 0;
    end else if (we) begin
      case (sel)
        3'd0: begin mSie = wd[1]; mSpie = wd[5]; mSpp = wd[8]; end
        3'd1: mIe = {wd[9], wd[5], wd[1]};
        3'd3: mEpc = wd;
        3'd4: begin mCIrq = wd[31]; mCode = wd[3:0]; end
        3'd5: mVec = {wd[31:2], 2'b00};
        default: ;
      endcase
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    mVec = RVEC;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int s = 0; s < 8; s++) begin
      csrSel = s[2:0]; #1;
      check("R1", csrRdata, modelRead(s[2:0], 3'b000));
    end
    check("R1", {31'd0, redirectValid}, 32'd0);
    rstN = 1'b1;
    // directed setup and corner cases
    step(0, 0, 0, 32'h10, 0, 0, 1, 3'd5, 32'h0000_1203);  // R8 vector masking
    step(0, 0, 0, 32'h14, 0, 0, 1, 3'd1, 32'hFFFF_FFFF);  // enable all
    step(3'b111, 0, 0, 32'h18, 0, 0, 0, 3'd2, 0);        // R2 SIE off: no trap
    step(0, 0, 0, 32'h1C, 0, 0, 1, 3'd0, 32'h0000_0002);  // SIE on
    step(3'b111, 0, 0, 32'h20, 0, 0, 1, 3'd3, 32'hDEAD);  // R4 ext wins, write dropped
    step(0, 0, 0, 32'h24, 1, 0, 0, 3'd4, 0);              // cause read
    step(0, 0, 0, 32'h28, 1, 0, 0, 3'd0, 0);              // R6 status read
    step(3'b011, 0, 0, 32'h2C, 1, 1, 0, 3'd3, 0);         // R7 return
    step(3'b011, 0, 0, 32'h30, 0, 0, 0, 3'd4, 0);         // R4 software over timer
    step(0, 0, 0, 32'h34, 1, 1, 0, 3'd4, 0);              // return
    step(3'b010, 1, 4'd8, 32'h38, 0, 1, 0, 3'd0, 0);      // R3 exception beats all
    step(0, 0, 0, 32'h3C, 1, 0, 0, 3'd4, 0);
    step(0, 0, 0, 32'h40, 1, 1, 0, 3'd0, 0);
    step(0, 0, 0, 32'h44, 1, 0, 1, 3'd1, 32'h0);          // disable all sources
    step(3'b111, 0, 0, 32'h48, 1, 0, 0, 3'd2, 0);         // R2 pending only
    for (int n = 0; n < 4000; n++) begin
      bit [31:0] r = $urandom;
      step(r[2:0], r[7:4] == 0, r[11:8], $urandom, r[12], r[16:13] == 0,
           r[18:17] == 0, r[21:19],
           r[22] ? $urandom : {22'd0, r[31:23], r[23]});
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule